// File: doc/BRIEF.md
# Double-Rate Output Word Serializer

This block takes one wide parallel word per slow-clock period and turns it into a stream of element pairs for a double-data-rate output pin. A word holds `2*RATIO` elements of `EW` bits each. Elements with even indices go to the rise lane, which a pin register sends on the rising edge of the fast clock. Elements with odd indices go to the fall lane, which is sent on the falling edge. Each lane is a `RATIO`:1 shifter clocked by the fast clock. The total ratio is therefore `2*RATIO`:1, and the pin carries two elements per fast cycle.

The slow clock and the fast clock come from one PLL and are edge-aligned. The slow clock runs at the fast rate divided by `RATIO`. Because of this, the block needs no synchronizer. A phase counter in the fast domain marks the fast edge that falls on a slow edge, and the word is captured on that edge. The counter is reset together with the slow domain. The source holds `word_in` and `word_valid` for a full slow period, launched from the slow edge.

If no word is offered at a capture edge, both lanes drive a fixed idle element and the valid flag stays low for that frame. With `RATIO` = 1 the shifters reduce to plain rise and fall registers that are loaded on every fast cycle. One instance serves one data line and can be replicated across a bus.

Top module: `ddr_word_serializer`

## Requirements
- R1: Element i of a word occupies `word_in[i*EW +: EW]`. In the j-th fast cycle of a frame (j = 0 .. RATIO-1), `rise_data` carries element 2j and `fall_data` carries element 2j+1, so the pin order is element 0, 1, 2, and so on up to the last element.
- R2: A phase counter runs from 0 to RATIO-1 and then wraps to 0. The word is captured only on a fast edge where the phase is 0. The first capture is at the first active edge after reset is released. Values of `word_in` and `word_valid` at any other edge have no effect on the outputs.
- R3: Frames follow each other with no gap. Every element of every word appears on its lane exactly once, and no element is repeated or skipped across the boundary between two frames.
- R4: `out_valid` is 1 for all RATIO cycles of a frame captured with `word_valid` = 1. It is 0 for a frame captured with `word_valid` = 0.
- R5: When `word_valid` is 0 at a capture edge, both lanes drive `IDLE_VAL` for the whole frame.
- R6: While `rst_n` is 0, sampled at a fast edge (synchronous, active low), `out_valid` is 0, both lanes drive `IDLE_VAL`, and the phase returns to 0.
- R7: `RATIO` may be 1, 2 or 4. With `RATIO` = 1 a word of two elements is captured on every fast edge: element 0 goes to `rise_data` and element 1 goes to `fall_data`.
- R8: The first element pair of a word appears on the outputs right after the capture edge, through one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast serializer clock, edge-aligned with the slow clock |
| rst_n | input | 1 | Synchronous active-low reset, shared with the slow domain |
| word_in | input | 2*RATIO*EW | Parallel word, element i at bits i*EW upward |
| word_valid | input | 1 | The word at the next capture edge carries data |
| rise_data | output | EW | Element for the rising edge of the pin |
| fall_data | output | EW | Element for the falling edge of the pin |
| out_valid | output | 1 | The current pair belongs to a valid word |

## Verification
At a capture edge, the shifters load the next word in the same cycle that they would otherwise shift out the last pair of the previous frame. The reload of the valid flag also lands in that cycle. The bench sends frames back to back and alternates valid and idle words. It judges each boundary on the first pair of the new word, on the valid flag, and on the absence of a leftover or repeated element. Between capture edges the bench drives inverted data and a flipped valid bit. If the frame in flight does not change, those inputs were correctly ignored.

// File: rtl/ser_pkg.sv
// Package: shared checks for the double-rate word serializer.
// Assumes: callers pass the per-lane ratio as a plain integer.
package ser_pkg;

    // Tells whether a per-lane ratio is one the serializer supports.
    function automatic bit ratio_supported(input int ratio);
        return (ratio == 1) || (ratio == 2) || (ratio == 4);
    endfunction

endpackage

// File: rtl/ser_phase_ctr.sv
// Module: fast-domain phase counter that marks the capture edge.
// Does: counts fast cycles within one slow period and raises load_now
//       on the cycle whose closing edge coincides with a slow edge.
// Assumes: fast clock = RATIO x slow clock, edge-aligned; reset shared
//          with the slow domain so phase 0 lines up with a slow edge.
module ser_phase_ctr #(
    parameter int RATIO = 4
) (
    input  logic clk_fast,
    input  logic rst_n,
    output logic load_now
);
    generate
        if (RATIO == 1) begin : g_every
            // Every fast edge is a slow edge: always capture.
            assign load_now = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
            logic [CW-1:0] phase;

            // Advance the phase and wrap after the last fast cycle.
            always_ff @(posedge clk_fast) begin
                if (!rst_n)
                    phase <= '0;
                else if (phase == LAST)
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign load_now = (phase == '0);

            AST_PHASE_WRAP: assert property (@(posedge clk_fast) disable iff (!rst_n)
                (phase == LAST) |=> (phase == '0)); // R2
            AST_LOAD_SPACING: assert property (@(posedge clk_fast) disable iff (!rst_n)
                load_now |=> !load_now); // R2
        end
    endgenerate
endmodule

// File: rtl/ser_word_split.sv
// Module: splits a parallel word into even (rise) and odd (fall) halves.
// Does: element 2i goes to slot i of the rise half and element 2i+1 to
//       slot i of the fall half; an invalid word becomes idle elements.
// Assumes: purely combinational, used ahead of the lane shifters.
module ser_word_split #(
    parameter int EW = 1,
    parameter int RATIO = 4,
    parameter logic [EW-1:0] IDLE_VAL = '0
) (
    input  logic [2*RATIO*EW-1:0] word,
    input  logic                  valid,
    output logic [RATIO*EW-1:0]   rise_half,
    output logic [RATIO*EW-1:0]   fall_half
);
    generate
        for (genvar i = 0; i < RATIO; i++) begin : g_slot
            // Route one even/odd element pair, or idle when invalid.
            assign rise_half[i*EW +: EW] = valid ? word[(2*i)*EW +: EW]   : IDLE_VAL;
            assign fall_half[i*EW +: EW] = valid ? word[(2*i+1)*EW +: EW] : IDLE_VAL;
        end
    endgenerate
endmodule

// File: rtl/ser_lane_shift.sv
// Module: one lane's DEPTH:1 shifter on the fast clock.
// Does: loads DEPTH elements on load, then presents them at head one per
//       cycle, slot 0 first, shifting idle elements in behind.
// Assumes: load arrives every DEPTH cycles, so shifted-in idle is never shown.
module ser_lane_shift #(
    parameter int EW = 1,
    parameter int DEPTH = 4,
    parameter logic [EW-1:0] IDLE_VAL = '0
) (
    input  logic                  clk_fast,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [DEPTH*EW-1:0]   load_word,
    output logic [EW-1:0]         head
);
    generate
        if (DEPTH == 1) begin : g_direct
            logic [EW-1:0] rg;
            // Direct lane register, reloaded whenever load is high.
            always_ff @(posedge clk_fast) begin
                if (!rst_n)
                    rg <= IDLE_VAL;
                else if (load)
                    rg <= load_word;
            end
            assign head = rg;
        end else begin : g_shift
            logic [DEPTH*EW-1:0] sh;
            // Load a new group, or move the next element into slot 0.
            always_ff @(posedge clk_fast) begin
                if (!rst_n)
                    sh <= {DEPTH{IDLE_VAL}};
                else if (load)
                    sh <= load_word;
                else
                    sh <= {IDLE_VAL, sh[DEPTH*EW-1:EW]};
            end
            assign head = sh[EW-1:0];
        end
    endgenerate
endmodule

// File: rtl/ddr_word_serializer.sv
// Module: top of the double-rate output word serializer.
// Does: captures a 2*RATIO-element word on each slow edge and emits it as
//       rise/fall element pairs over RATIO fast cycles, flagged by out_valid.
// Assumes: fast and slow clocks from one PLL, edge-aligned; word_in and
//          word_valid held for a full slow period; pin DDR register external.
module ddr_word_serializer #(
    parameter int EW = 1,
    parameter int RATIO = 4,
    parameter logic [EW-1:0] IDLE_VAL = '0
) (
    input  logic                  clk_fast,
    input  logic                  rst_n,
    input  logic [2*RATIO*EW-1:0] word_in,
    input  logic                  word_valid,
    output logic [EW-1:0]         rise_data,
    output logic [EW-1:0]         fall_data,
    output logic                  out_valid
);
    import ser_pkg::*;

    initial begin
        if (!ratio_supported(RATIO))
            $error("ddr_word_serializer: RATIO must be 1, 2 or 4");
    end

    logic                load_now;
    logic [RATIO*EW-1:0] rise_half;
    logic [RATIO*EW-1:0] fall_half;

    ser_phase_ctr #(.RATIO(RATIO)) u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .load_now (load_now)
    );

    ser_word_split #(.EW(EW), .RATIO(RATIO), .IDLE_VAL(IDLE_VAL)) u_split (
        .word      (word_in),
        .valid     (word_valid),
        .rise_half (rise_half),
        .fall_half (fall_half)
    );

    ser_lane_shift #(.EW(EW), .DEPTH(RATIO), .IDLE_VAL(IDLE_VAL)) u_rise (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .load      (load_now),
        .load_word (rise_half),
        .head      (rise_data)
    );

    ser_lane_shift #(.EW(EW), .DEPTH(RATIO), .IDLE_VAL(IDLE_VAL)) u_fall (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .load      (load_now),
        .load_word (fall_half),
        .head      (fall_data)
    );

    // Frame valid flag, taken from word_valid at each capture edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (load_now)
            out_valid <= word_valid;
    end

    AST_FIRST_PAIR: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (load_now && word_valid) |=> (out_valid
            && rise_data == $past(word_in[EW-1:0])
            && fall_data == $past(word_in[2*EW-1:EW]))); // R1
    AST_IDLE_FILL: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (load_now && !word_valid) |=> (!out_valid
            && rise_data == IDLE_VAL && fall_data == IDLE_VAL)); // R5
    AST_VALID_HOLD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !load_now |=> $stable(out_valid)); // R4
endmodule

// File: tb/tb_ddr_word_serializer.sv
module tb_ddr_word_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 2;
    localparam logic [EW-1:0] IDLE = 2'b01;

    logic        clk_fast = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] w4 = '0;
    logic        v4 = 1'b0;
    logic [1:0]  r4, f4;
    logic        o4;
    logic [3:0]  w1 = '0;
    logic        v1 = 1'b0;
    logic [1:0]  r1, f1;
    logic        o1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    ddr_word_serializer #(.EW(EW), .RATIO(4), .IDLE_VAL(IDLE)) dut (
        .clk_fast(clk_fast), .rst_n(rst_n), .word_in(w4), .word_valid(v4),
        .rise_data(r4), .fall_data(f4), .out_valid(o4)
    );

    ddr_word_serializer #(.EW(EW), .RATIO(1), .IDLE_VAL(IDLE)) dut1 (
        .clk_fast(clk_fast), .rst_n(rst_n), .word_in(w1), .word_valid(v1),
        .rise_data(r1), .fall_data(f1), .out_valid(o1)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] el(input logic [15:0] w, input int i);
        return w[i*2 +: 2];
    endfunction

    // Reset state, with live inputs that must not leak through (R6).
    task automatic t_reset();
        rst_n = 1'b0;
        w4 = 16'hBEEF; v4 = 1'b1; w1 = 4'hE; v1 = 1'b1;
        repeat (3) @(posedge clk_fast);
        @(negedge clk_fast);
        check("R6 lanes", 8'({r4, f4}), 8'({IDLE, IDLE}));
        check("R6 valid", 8'(o4), 8'(0));
        check("R6 x1", 8'({r1, f1, o1}), 8'({IDLE, IDLE, 1'b0}));
        v1 = 1'b0;
        rst_n = 1'b1;
    endtask

    // One RATIO=4 frame; the call sits at the negedge before the capture edge.
    task automatic send4(input string req, input logic [15:0] word, input logic valid);
        w4 = word; v4 = valid;
        for (int j = 0; j < 4; j++) begin
            @(posedge clk_fast);
            @(negedge clk_fast);
            if (valid)
                check(req, 8'({r4, f4}), 8'({el(word, 2*j), el(word, 2*j+1)}));
            else
                check({req, " R5 idle"}, 8'({r4, f4}), 8'({IDLE, IDLE}));
            check({req, " R4 valid"}, 8'(o4), 8'(valid));
            if (j < 3) begin
                // Off-phase junk, to be ignored (R2).
                w4 = ~word ^ 16'(j * 16'h1357);
                v4 = ~valid;
            end
        end
    endtask

    // RATIO=1 variant: a capture on every fast edge (R7).
    task automatic t_ratio1();
        logic [3:0] ws [4] = '{4'h6, 4'h9, 4'hC, 4'h3};
        for (int k = 0; k < 4; k++) begin
            w1 = ws[k]; v1 = (k != 2);
            @(posedge clk_fast);
            @(negedge clk_fast);
            if (k != 2)
                check("R7 pair", 8'({r1, f1, o1}), 8'({ws[k][1:0], ws[k][3:2], 1'b1}));
            else
                check("R7 idle", 8'({r1, f1, o1}), 8'({IDLE, IDLE, 1'b0}));
        end
        v1 = 1'b0;
    endtask

    initial begin
        t_reset();
        send4("R8 R1 first word", 16'hE4B1, 1'b1);
        send4("R3 back-to-back", 16'h1B4E, 1'b1);
        send4("R3 back-to-back", 16'h0FF0, 1'b1);
        send4("R5 gap", 16'hAAAA, 1'b0);
        send4("R1 after idle", 16'h3C96, 1'b1);
        send4("R2 ignore", 16'h5A5A, 1'b0);
        send4("R3 after idle", 16'hC369, 1'b1);
        t_ratio1();
        // Reset mid-frame restarts the phase at 0 (R6, R2).
        send4("R1 pre-reset", 16'h9D2F, 1'b1);
        @(posedge clk_fast);
        @(negedge clk_fast);
        t_reset();
        send4("R2 phase restart", 16'h72E1, 1'b1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_fast);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule